// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block forms the status word that a read returns while a non-volatile memory array is busy with an internal program or erase, or while an erase is held in suspension. It takes the current operation state, the read address, the set of sectors marked for erase, the address and data of the word being programmed, a timeout flag and a read strobe. From these it builds a status word that carries a data-polling bit, a free-running toggle bit, a sector-selective toggle bit and a timeout bit. It also drives a ready signal. When no status applies, the word read from the array passes through unchanged.

Software tells a program from an erase, and an erasing sector from a suspended one, by comparing two consecutive reads. Both toggle bits therefore advance once per completed read, at the cycle in which the strobe is released. A strobe held high for many cycles counts as one read. A one-cycle command-start pulse, given at the rising edge of the last write strobe of a command, sets the block busy and clears both toggle bits. The block returns to ready when the operation leaves the busy states.

Top module: `eop_status_gen`

## Requirements
- R1: In the idle state (op_state 0), and for reads in a suspend state that are not status reads under R5 or R6, dout equals array_data. Once an operation ends and the state returns to idle, reads show true array data.
- R2: In the program state (op_state 1), dout[7] is the complement of prog_data[7]. The status layout is: dout[7] polling, dout[6] toggle, dout[5] timeout, dout[2] sector toggle, and every other bit 0.
- R3: In the program and erase states (op_state 1 and 2), dout[6] inverts once after each completed read, at the clock edge that sees rd_en fall. A strobe held high through several cycles gives the same value on every cycle.
- R4: In the erase state, dout[7] is 0. dout[2] inverts after a read only when the sector of rd_addr (its top SECT_BITS bits) is set in erase_mask. Reads from other sectors leave dout[2] unchanged.
- R5: In the erase-suspended state (op_state 3), a read from a sector set in erase_mask returns dout[7]=1, dout[5]=0, dout[6] unchanged and dout[2] inverting once per read.
- R6: In the program-during-suspend state (op_state 4), a read at prog_addr returns dout[2]=1 and dout[7]=~prog_data[7], and dout[6] inverts per read. A read from a masked sector behaves as in R5.
- R7: While tmo_flag is high in the program, erase or program-during-suspend status reads, dout[5] is 1 and dout[6] keeps inverting on every read.
- R8: ready goes low in the cycle after a cmd_start pulse, and that pulse clears both toggle bits to 0. ready returns high one cycle after op_state leaves the busy states (1, 2, 4) for idle or erase-suspended. ready is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_state | input | 3 | 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend |
| rd_addr | input | AW | Read address |
| erase_mask | input | 2**SECT_BITS | One bit per sector marked for erase |
| prog_addr | input | AW | Address of the word being programmed |
| prog_data | input | DW | Data being programmed |
| array_data | input | DW | Data read from the array |
| tmo_flag | input | 1 | Internal time limit exceeded |
| rd_en | input | 1 | Read strobe, active high |
| cmd_start | input | 1 | One-cycle pulse at the end of the last write of a command |
| dout | output | DW | Status word or passed-through array data |
| ready | output | 1 | 1 when idle or suspended, 0 while an operation runs |

## Verification
The assertions assume that op_state holds only the five listed encodings and that cmd_start is a single-cycle pulse. They also assume that rd_addr and op_state stay steady from the rise of rd_en until after the edge that sees it fall, because the toggle decision is captured while the strobe is high. The bench changes every input only on the falling clock edge and holds the address through each strobe release. It starts each new operation with a cmd_start pulse, so its own toggle model begins at the same known zero as the design.

// File: rtl/eop_status_pkg.sv
package eop_status_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_ESUSP = 3'd3,
    OP_SPROG = 3'd4
  } op_state_e;

  localparam int POLL_POS = 7;
  localparam int TOG_POS  = 6;
  localparam int TMO_POS  = 5;
  localparam int ETOG_POS = 2;

  // States in which an embedded algorithm is actively running.
  function automatic logic op_running(op_state_e s);
    return (s == OP_PROG) || (s == OP_ERASE) || (s == OP_SPROG);
  endfunction

  // Assemble the low status byte from its flags.
  function automatic logic [7:0] pack_status(logic poll, logic tog, logic tmo, logic etog);
    logic [7:0] b;
    b = 8'h00;
    b[POLL_POS] = poll;
    b[TOG_POS]  = tog;
    b[TMO_POS]  = tmo;
    b[ETOG_POS] = etog;
    return b;
  endfunction

endpackage

// File: rtl/eop_addr_match.sv
module eop_addr_match #(
  parameter int AW        = 12,
  parameter int SECT_BITS = 3,
  localparam int NSECT    = 1 << SECT_BITS
) (
  input  logic [AW-1:0]    rd_addr,
  input  logic [AW-1:0]    prog_addr,
  input  logic [NSECT-1:0] erase_mask,
  output logic             in_erase_sect,
  output logic             at_prog_addr
);

  function automatic logic [SECT_BITS-1:0] sector_of(logic [AW-1:0] a);
    return a[AW-1 -: SECT_BITS];
  endfunction

  logic [SECT_BITS-1:0] rd_sect;
  logic [NSECT-1:0]     sect_hit;

  assign rd_sect = sector_of(rd_addr);

  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    assign sect_hit[i] = erase_mask[i] && (rd_sect == SECT_BITS'(i));
  end

  assign in_erase_sect = |sect_hit;
  assign at_prog_addr  = (rd_addr == prog_addr);

endmodule

// File: rtl/eop_status_mux.sv
module eop_status_mux
  import eop_status_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_state_e        state,
  input  logic             in_erase_sect,
  input  logic             at_prog_addr,
  input  logic             prog_msb,
  input  logic             tmo_flag,
  input  logic             tog_q,
  input  logic             etog_q,
  input  logic [DW-1:0]    array_data,
  output logic [DW-1:0]    dout,
  output logic             tog_adv,
  output logic             etog_adv
);

  logic sel_status;
  logic poll_b, tog_b, tmo_b, etog_b;

  always_comb begin
    sel_status = 1'b0;
    poll_b     = 1'b0;
    tog_b      = tog_q;
    tmo_b      = 1'b0;
    etog_b     = etog_q;
    tog_adv    = 1'b0;
    etog_adv   = 1'b0;
    unique case (state)
      OP_PROG: begin
        sel_status = 1'b1;
        poll_b     = ~prog_msb;
        tmo_b      = tmo_flag;
        tog_adv    = 1'b1;
      end
      OP_ERASE: begin
        sel_status = 1'b1;
        poll_b     = 1'b0;
        tmo_b      = tmo_flag;
        tog_adv    = 1'b1;
        etog_adv   = in_erase_sect;
      end
      OP_ESUSP: begin
        if (in_erase_sect) begin
          sel_status = 1'b1;
          poll_b     = 1'b1;
          etog_adv   = 1'b1;
        end
      end
      OP_SPROG: begin
        if (at_prog_addr) begin
          sel_status = 1'b1;
          poll_b     = ~prog_msb;
          tmo_b      = tmo_flag;
          etog_b     = 1'b1;
          tog_adv    = 1'b1;
        end else if (in_erase_sect) begin
          sel_status = 1'b1;
          poll_b     = 1'b1;
          etog_adv   = 1'b1;
        end
      end
      default: sel_status = 1'b0;
    endcase
  end

  always_comb begin
    if (sel_status) begin
      dout      = '0;
      dout[7:0] = pack_status(poll_b, tog_b, tmo_b, etog_b);
    end else begin
      dout = array_data;
    end
  end

endmodule

// File: rtl/eop_toggle_unit.sv
module eop_toggle_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic cmd_start,
  input  logic tog_adv,
  input  logic etog_adv,
  output logic rd_fall,
  output logic tog_q,
  output logic etog_q
);

  logic rd_q;
  logic cap_tog, cap_etog;

  assign rd_fall = rd_q && !rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      cap_tog  <= 1'b0;
      cap_etog <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (rd_en) begin
        cap_tog  <= tog_adv;
        cap_etog <= etog_adv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      etog_q <= 1'b0;
    end else if (cmd_start) begin
      tog_q  <= 1'b0;
      etog_q <= 1'b0;
    end else if (rd_fall) begin
      if (cap_tog)  tog_q  <= ~tog_q;
      if (cap_etog) etog_q <= ~etog_q;
    end
  end

endmodule

// File: rtl/eop_busy_track.sv
module eop_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic running,
  output logic ready
);

  logic busy_q, run_q, run_end;

  assign run_end = run_q && !running;
  assign ready   = !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q <= running;
      if (cmd_start)    busy_q <= 1'b1;
      else if (run_end) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/eop_status_gen.sv
module eop_status_gen
  import eop_status_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 12,
  parameter int SECT_BITS = 3,
  localparam int NSECT    = 1 << SECT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_state,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NSECT-1:0] erase_mask,
  input  logic [AW-1:0]    prog_addr,
  input  logic [DW-1:0]    prog_data,
  input  logic [DW-1:0]    array_data,
  input  logic             tmo_flag,
  input  logic             rd_en,
  input  logic             cmd_start,
  output logic [DW-1:0]    dout,
  output logic             ready
);

  op_state_e state;
  logic in_erase_sect, at_prog_addr;
  logic tog_adv, etog_adv;
  logic rd_fall_w, tog_q_w, etog_q_w;
  logic running;
  logic unused_prog_bits;

  assign state            = op_state_e'(op_state);
  assign running          = op_running(state);
  assign unused_prog_bits = ^{prog_data[DW-1:8], prog_data[6:0]};

  eop_addr_match #(.AW(AW), .SECT_BITS(SECT_BITS)) u_match (
    .rd_addr       (rd_addr),
    .prog_addr     (prog_addr),
    .erase_mask    (erase_mask),
    .in_erase_sect (in_erase_sect),
    .at_prog_addr  (at_prog_addr)
  );

  eop_status_mux #(.DW(DW)) u_mux (
    .state         (state),
    .in_erase_sect (in_erase_sect),
    .at_prog_addr  (at_prog_addr),
    .prog_msb      (prog_data[7]),
    .tmo_flag      (tmo_flag),
    .tog_q         (tog_q_w),
    .etog_q        (etog_q_w),
    .array_data    (array_data),
    .dout          (dout),
    .tog_adv       (tog_adv),
    .etog_adv      (etog_adv)
  );

  eop_toggle_unit u_tog (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .cmd_start (cmd_start),
    .tog_adv   (tog_adv),
    .etog_adv  (etog_adv),
    .rd_fall   (rd_fall_w),
    .tog_q     (tog_q_w),
    .etog_q    (etog_q_w)
  );

  eop_busy_track u_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .running   (running),
    .ready     (ready)
  );

endmodule

// File: rtl/eop_status_chk.sv
module eop_status_chk
  import eop_status_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_state,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] prog_addr,
  input logic [DW-1:0] prog_data,
  input logic [DW-1:0] array_data,
  input logic          tmo_flag,
  input logic          cmd_start,
  input logic [DW-1:0] dout,
  input logic          ready,
  input logic          rd_fall_w,
  input logic          tog_q_w
);

  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_IDLE) |-> (dout == array_data));

  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_PROG) |-> (dout[7] == ~prog_data[7]));

  // R3
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fall_w && !cmd_start) |=> $stable(tog_q_w));

  // R6
  sprog_etog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_SPROG && rd_addr == prog_addr) |-> dout[2]);

  // R7
  tmo_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_state == OP_PROG || op_state == OP_ERASE) && tmo_flag) |-> dout[5]);

  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !ready);

endmodule

bind eop_status_gen eop_status_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_state   (op_state),
  .rd_addr    (rd_addr),
  .prog_addr  (prog_addr),
  .prog_data  (prog_data),
  .array_data (array_data),
  .tmo_flag   (tmo_flag),
  .cmd_start  (cmd_start),
  .dout       (dout),
  .ready      (ready),
  .rd_fall_w  (rd_fall_w),
  .tog_q_w    (tog_q_w)
);

// File: tb/sim_eop_status_gen.sv
module sim_eop_status_gen;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int SB = 3;
  localparam int NS = 1 << SB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op_state = 3'd0;
  logic [AW-1:0] rd_addr = '0;
  logic [NS-1:0] erase_mask = '0;
  logic [AW-1:0] prog_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic [DW-1:0] array_data = 16'hA5C3;
  logic          tmo_flag = 1'b0;
  logic          rd_en = 1'b0;
  logic          cmd_start = 1'b0;
  logic [DW-1:0] dout;
  logic          ready;

  int checks = 0;
  int errors = 0;
  logic mt = 1'b0;  // model of toggle bit
  logic me = 1'b0;  // model of sector toggle bit

  always #2.5 clk = ~clk;

  eop_status_gen #(.DW(DW), .AW(AW), .SECT_BITS(SB)) u0 (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .rd_addr(rd_addr),
    .erase_mask(erase_mask), .prog_addr(prog_addr), .prog_data(prog_data),
    .array_data(array_data), .tmo_flag(tmo_flag), .rd_en(rd_en),
    .cmd_start(cmd_start), .dout(dout), .ready(ready)
  );

  // Expected status word: bit7 poll, bit6 toggle, bit5 timeout, bit2 sector toggle.
  function automatic logic [DW-1:0] sw(logic p, logic t, logic o, logic e);
    return DW'({p, t, o, 2'b00, e, 2'b00});
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    rd_addr = a;
    rd_en = 1'b1;
    #1 v = dout;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_cmd();
    @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    mt = 1'b0;
    me = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R8 ready after reset", DW'(ready), DW'(1));
    rd(12'h123, v);
    chk("R1 idle passthrough", v, 16'hA5C3);
  endtask

  task automatic t_program();
    logic [DW-1:0] v;
    start_cmd();
    chk("R8 busy after cmd", DW'(ready), DW'(0));
    op_state = 3'd1;
    prog_data = 16'h0035;
    for (int i = 0; i < 3; i++) begin
      rd(12'h040, v);
      chk("R2/R3 program status", v, sw(1'b1, mt, 1'b0, me));
      mt = ~mt;
    end
    prog_data = 16'h00B0;
    rd(12'h040, v);
    chk("R2 poll complement of bit7=1", v, sw(1'b0, mt, 1'b0, me));
    mt = ~mt;
    // held strobe: constant value across cycles
    @(negedge clk);
    rd_en = 1'b1;
    #1 v = dout;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1 chk("R3 held read steady", dout, v);
    end
    rd_en = 1'b0;
    mt = ~mt;
    rd(12'h040, v);
    chk("R3 single flip after held read", v, sw(1'b0, mt, 1'b0, me));
    mt = ~mt;
    @(negedge clk);
    op_state = 3'd0;
    array_data = 16'h1234;
    @(negedge clk);
    chk("R8 ready after completion", DW'(ready), DW'(1));
    rd(12'h040, v);
    chk("R1 true data after completion", v, 16'h1234);
  endtask

  task automatic t_erase();
    logic [DW-1:0] v;
    start_cmd();
    op_state = 3'd2;
    erase_mask = 8'b0000_0100;  // sector 2: addresses 0x400..0x5FF
    rd(12'h410, v);
    chk("R4 erase in sector", v, sw(1'b0, mt, 1'b0, me));
    mt = ~mt; me = ~me;
    rd(12'h410, v);
    chk("R4 erase sector toggled", v, sw(1'b0, mt, 1'b0, me));
    mt = ~mt; me = ~me;
    rd(12'h010, v);
    chk("R4 erase outside sector", v, sw(1'b0, mt, 1'b0, me));
    mt = ~mt;
    rd(12'h610, v);
    chk("R4 sector bit held outside", v, sw(1'b0, mt, 1'b0, me));
    mt = ~mt;
  endtask

  task automatic t_suspend();
    logic [DW-1:0] v;
    @(negedge clk);
    op_state = 3'd3;
    array_data = 16'h5A5A;
    @(negedge clk);
    chk("R8 ready in suspend", DW'(ready), DW'(1));
    for (int i = 0; i < 2; i++) begin
      rd(12'h4F0, v);
      chk("R5 suspended sector", v, sw(1'b1, mt, 1'b0, me));
      me = ~me;
    end
    rd(12'h010, v);
    chk("R1 suspend other sector", v, 16'h5A5A);
    // program during suspend
    op_state = 3'd4;
    prog_addr = 12'h020;
    prog_data = 16'h0080;
    tmo_flag = 1'b0;
    rd(12'h020, v);
    chk("R6 program addr in suspend", v, sw(1'b0, mt, 1'b0, 1'b1));
    mt = ~mt;
    rd(12'h020, v);
    chk("R6 toggle advances", v, sw(1'b0, mt, 1'b0, 1'b1));
    mt = ~mt;
    rd(12'h404, v);
    chk("R6 masked sector read", v, sw(1'b1, mt, 1'b0, me));
    me = ~me;
    rd(12'h030, v);
    chk("R1 suspend-program other addr", v, 16'h5A5A);
    @(negedge clk);
    op_state = 3'd0;
    erase_mask = '0;
  endtask

  task automatic t_timeout();
    logic [DW-1:0] v;
    start_cmd();
    op_state = 3'd1;
    prog_data = 16'h0000;
    tmo_flag = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd(12'h100, v);
      chk("R7 timeout keeps toggling", v, sw(1'b1, mt, 1'b1, me));
      mt = ~mt;
    end
    chk("R8 still busy on timeout", DW'(ready), DW'(0));
    @(negedge clk);
    op_state = 3'd0;
    tmo_flag = 1'b0;
    @(negedge clk);
    chk("R8 ready after abort", DW'(ready), DW'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_suspend();
    t_timeout();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule